// File: doc/BRIEF.md
# Dual-Channel APB Down-Counter Timer

Two independent decrementing counters share one APB slave port and one timer tick enable. Software writes a start value, sets a mode in the control register and enables the channel. The channel then counts down once per prescaled tick. When it reaches zero it raises a raw interrupt flag. The flag drives a per-channel interrupt line when its enable bit is set, and the two lines are also ORed onto a combined output.

At run time each channel picks a tick divider of 1, 16 or 256 and a counter width of 16 or 32 bits. It also picks what happens on the tick after zero: wrap to all ones (free-running), reload from the reload register (periodic), or stop at zero (one-shot). A background reload write changes only the value used at the next reload, while a direct load write restarts the count at once.

Top module: `dual_timer_apb`

## Requirements
- R1: Register map per channel, with word offsets from the channel base: 0x00 load, 0x04 current value, 0x08 control, 0x0C interrupt clear, 0x10 raw status, 0x14 masked status, 0x18 background load. Channel 2 sits at base 0x20. All registers read 0 after reset, and unmapped or misaligned addresses read 0.
- R2: While the control enable bit (bit 7) is 1, the value drops by one on each prescaled tick. A cycle with tickEn low does not count.
- R3: Control bits 3:2 select the divider: 0 counts on every tick, 1 on every 16th tick and 2 on every 256th tick. Value 3 behaves like 2.
- R4: The raw status (bit 0) becomes 1 on the tick that takes the value from 1 to 0, and reads 0 before that tick.
- R5: In free-running mode (bit 6 = 0, bit 0 = 0), the tick after zero wraps the value to 0xFFFF in 16-bit mode and to 0xFFFFFFFF in 32-bit mode (bit 1 = 1).
- R6: In periodic mode (bit 6 = 1), the tick after zero reloads the value from the reload register.
- R7: In one-shot mode (bit 0 = 1), the value stays at zero, even if bit 6 is also set.
- R8: In 16-bit mode (bit 1 = 0), the value reads and counts only the low 16 bits of the loaded value.
- R9: A write of any data to interrupt clear sets the raw status to 0. A clear takes priority over a set in the same cycle.
- R10: Masked status equals raw status AND the interrupt enable bit (bit 5). irqOne and irqTwo follow the channels' masked status, and irqAny is their OR.
- R11: A load write sets both the value and the reload register and restarts the divider. Reading the load or background load register returns the reload register.
- R12: A background load write changes the reload register but leaves the current value unchanged.
- R13: Writing 0 to control stops the channel, and the value then holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and timer clock |
| rstN | input | 1 | Active-low asynchronous reset |
| tickEn | input | 1 | Shared timer tick enable |
| pSel | input | 1 | APB select |
| pEnable | input | 1 | APB access phase |
| pWrite | input | 1 | APB write |
| pAddr | input | ADDR_W (12) | APB byte address |
| pWdata | input | DATA_W (32) | APB write data |
| pRdata | output | DATA_W (32) | APB read data |
| irqOne | output | 1 | Channel 1 masked interrupt |
| irqTwo | output | 1 | Channel 2 masked interrupt |
| irqAny | output | 1 | OR of both channel interrupts |

## Verification
The bench builds the block with its default parameters: 32-bit registers, a 16-bit narrow view, divider stages at 4 and 8 bits, and a 12-bit address. Small load values bring the 32-bit wrap to all ones, the 256-tick divider and the periodic reload within a few thousand cycles. A load of 0x12345 exercises the 16-bit view, including a periodic reload that masks the reload value. Because tickEn is held low during bus accesses, every expected count follows from the number of enabled ticks alone.

// File: rtl/dtm_pkg.sv
package dtm_pkg;
  localparam int CTRL_W = 8;
  localparam int CH_LSB = 5;
  localparam logic [2:0] REG_LOAD  = 3'd0;
  localparam logic [2:0] REG_VALUE = 3'd1;
  localparam logic [2:0] REG_CTRL  = 3'd2;
  localparam logic [2:0] REG_CLR   = 3'd3;
  localparam logic [2:0] REG_RIS   = 3'd4;
  localparam logic [2:0] REG_MIS   = 3'd5;
  localparam logic [2:0] REG_BG    = 3'd6;

  typedef struct packed {
    logic wrLoad;
    logic wrBg;
    logic wrCtrl;
    logic wrClr;
  } chanStb_t;

  typedef struct packed {
    logic       en;
    logic       periodic;
    logic       intEn;
    logic       rsvd;
    logic [1:0] preSel;
    logic       wide;
    logic       oneShot;
  } ctrl_t;
endpackage

// File: rtl/dtm_channel.sv
module dtm_channel
  import dtm_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int NARROW_W = 16,
  parameter int PRE_W    = 8,
  parameter int PRE_MID  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickEn,
  input  chanStb_t          stb,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] valueOut,
  output logic [DATA_W-1:0] reloadOut,
  output logic [CTRL_W-1:0] ctrlOut,
  output logic              risOut,
  output logic              misOut
);
  localparam logic [DATA_W-1:0] NARROW_MASK =
    {{(DATA_W-NARROW_W){1'b0}}, {NARROW_W{1'b1}}};
  localparam logic [DATA_W-1:0] ONE = {{(DATA_W-1){1'b0}}, 1'b1};

  logic [DATA_W-1:0] count, reload, mask, cur;
  logic [PRE_W-1:0]  pre;
  ctrl_t             ctrl;
  logic              ris, preHit, step;

  assign mask = ctrl.wide ? '1 : NARROW_MASK;
  assign cur  = count & mask;

  always_comb begin
    unique case (ctrl.preSel)
      2'd0:    preHit = 1'b1;
      2'd1:    preHit = &pre[PRE_MID-1:0];
      default: preHit = &pre;
    endcase
  end

  assign step = ctrl.en && tickEn && preHit && !stb.wrLoad;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      count  <= '0;
      reload <= '0;
      pre    <= '0;
      ctrl   <= '0;
      ris    <= 1'b0;
    end else begin
      if (stb.wrLoad) begin
        count  <= wdata;
        reload <= wdata;
        pre    <= '0;
      end else begin
        if (ctrl.en && tickEn) pre <= pre + 1'b1;
        if (stb.wrBg) reload <= wdata;
        if (step) begin
          if (cur == '0) begin
            if (ctrl.oneShot)       count <= count;
            else if (ctrl.periodic) count <= reload & mask;
            else                    count <= mask;
          end else begin
            count <= (cur - ONE) & mask;
          end
        end
      end
      if (stb.wrCtrl)
        ctrl <= ctrl_t'({wdata[7:5], 1'b0, wdata[3:0]});
      if (stb.wrClr)                 ris <= 1'b0;
      else if (step && (cur == ONE)) ris <= 1'b1;
    end
  end

  assign valueOut  = cur;
  assign reloadOut = reload;
  assign ctrlOut   = ctrl;
  assign risOut    = ris;
  assign misOut    = ris && ctrl.intEn;

  // R11: a load write sets both value and reload
  p_load_r11: assert property (@(posedge clk) disable iff (!rstN)
    stb.wrLoad |=> (count == $past(wdata)) && (reloadOut == $past(wdata)));

  // R13: a stopped channel holds its count
  p_hold_off_r13: assert property (@(posedge clk) disable iff (!rstN)
    (!ctrl.en && !stb.wrLoad) |=> (count == $past(count)));

  // R4: the raw flag rises only as the value reaches zero
  p_rise_zero_r4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(risOut) |-> (valueOut == '0));

  // R9: any clear write leaves the raw flag at zero
  p_clear_r9: assert property (@(posedge clk) disable iff (!rstN)
    stb.wrClr |=> !risOut);

  // R7: one-shot stays at zero
  p_oneshot_r7: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.en && ctrl.oneShot && valueOut == '0 && !stb.wrLoad && !stb.wrCtrl)
      |=> (valueOut == '0));
endmodule

// File: rtl/dtm_regif.sv
module dtm_regif
  import dtm_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32,
  parameter int NCH    = 2
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          pSel,
  input  logic                          pEnable,
  input  logic                          pWrite,
  input  logic [ADDR_W-1:0]             pAddr,
  input  logic [NCH-1:0][DATA_W-1:0]    valueIn,
  input  logic [NCH-1:0][DATA_W-1:0]    reloadIn,
  input  logic [NCH-1:0][CTRL_W-1:0]    ctrlIn,
  input  logic [NCH-1:0]                risIn,
  input  logic [NCH-1:0]                misIn,
  output chanStb_t [NCH-1:0]            stbOut,
  output logic [DATA_W-1:0]             pRdata
);
  localparam int CH_W = (NCH > 1) ? $clog2(NCH) : 1;
  localparam int TOP_LSB = CH_LSB + CH_W;

  logic [CH_W-1:0] chIdx;
  logic [2:0]      regIdx;
  logic            inRange, wrEn;

  assign chIdx   = pAddr[CH_LSB +: CH_W];
  assign regIdx  = pAddr[4:2];
  assign inRange = (pAddr[ADDR_W-1:TOP_LSB] == '0) && (pAddr[1:0] == 2'b00)
                   && (int'(chIdx) < NCH);
  assign wrEn    = pSel && pEnable && pWrite && inRange;

  for (genvar c = 0; c < NCH; c++) begin : g_stb
    logic hit;
    assign hit = wrEn && (chIdx == CH_W'(c));
    assign stbOut[c].wrLoad = hit && (regIdx == REG_LOAD);
    assign stbOut[c].wrBg   = hit && (regIdx == REG_BG);
    assign stbOut[c].wrCtrl = hit && (regIdx == REG_CTRL);
    assign stbOut[c].wrClr  = hit && (regIdx == REG_CLR);
  end

  always_comb begin
    pRdata = '0;
    if (inRange) begin
      unique case (regIdx)
        REG_LOAD, REG_BG: pRdata = reloadIn[chIdx];
        REG_VALUE:        pRdata = valueIn[chIdx];
        REG_CTRL:         pRdata = {{(DATA_W-CTRL_W){1'b0}}, ctrlIn[chIdx]};
        REG_RIS:          pRdata = {{(DATA_W-1){1'b0}}, risIn[chIdx]};
        REG_MIS:          pRdata = {{(DATA_W-1){1'b0}}, misIn[chIdx]};
        default:          pRdata = '0;
      endcase
    end
  end

  // R1: at most one register strobe per bus access
  p_one_strobe_r1: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(stbOut));
endmodule

// File: rtl/dual_timer_apb.sv
module dual_timer_apb
  import dtm_pkg::*;
#(
  parameter int ADDR_W   = 12,
  parameter int DATA_W   = 32,
  parameter int NARROW_W = 16,
  parameter int PRE_W    = 8,
  parameter int PRE_MID  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickEn,
  input  logic              pSel,
  input  logic              pEnable,
  input  logic              pWrite,
  input  logic [ADDR_W-1:0] pAddr,
  input  logic [DATA_W-1:0] pWdata,
  output logic [DATA_W-1:0] pRdata,
  output logic              irqOne,
  output logic              irqTwo,
  output logic              irqAny
);
  localparam int NCH = 2;

  chanStb_t [NCH-1:0]         stb;
  logic [NCH-1:0][DATA_W-1:0] value, reload;
  logic [NCH-1:0][CTRL_W-1:0] ctrl;
  logic [NCH-1:0]             ris, mis;

  dtm_regif #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NCH(NCH)) i_regif (
    .clk(clk), .rstN(rstN), .pSel(pSel), .pEnable(pEnable), .pWrite(pWrite),
    .pAddr(pAddr), .valueIn(value), .reloadIn(reload), .ctrlIn(ctrl),
    .risIn(ris), .misIn(mis), .stbOut(stb), .pRdata(pRdata)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    dtm_channel #(.DATA_W(DATA_W), .NARROW_W(NARROW_W), .PRE_W(PRE_W),
                  .PRE_MID(PRE_MID)) i_channel (
      .clk(clk), .rstN(rstN), .tickEn(tickEn), .stb(stb[c]), .wdata(pWdata),
      .valueOut(value[c]), .reloadOut(reload[c]), .ctrlOut(ctrl[c]),
      .risOut(ris[c]), .misOut(mis[c])
    );
  end

  assign irqOne = mis[0];
  assign irqTwo = mis[1];
  assign irqAny = |mis;
endmodule

// File: tb/test_dual_timer_apb.sv
module test_dual_timer_apb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        tickEn = 1'b0;
  logic        pSel = 1'b0, pEnable = 1'b0, pWrite = 1'b0;
  logic [11:0] pAddr = '0;
  logic [31:0] pWdata = '0;
  logic [31:0] pRdata;
  logic        irqOne, irqTwo, irqAny;

  int nChecks = 0;
  int nFail = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  dual_timer_apb i_dual_timer_apb (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .pSel(pSel), .pEnable(pEnable),
    .pWrite(pWrite), .pAddr(pAddr), .pWdata(pWdata), .pRdata(pRdata),
    .irqOne(irqOne), .irqTwo(irqTwo), .irqAny(irqAny)
  );

  localparam logic [11:0] A_LOAD = 12'h00, A_VAL = 12'h04, A_CTRL = 12'h08,
                          A_CLR = 12'h0C, A_RIS = 12'h10, A_MIS = 12'h14,
                          A_BG = 12'h18, CH2 = 12'h20;

  typedef struct packed {
    logic [7:0]  ctrl;
    logic [31:0] load;
    logic [31:0] ticks;
    logic [31:0] expVal;
    logic        expRis;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t VECS [NV] = '{
    '{8'hA0, 32'd1000,    32'd500,  32'd500,      1'b0}, // R2 half way
    '{8'hA0, 32'd1000,    32'd1000, 32'd0,        1'b1}, // R4 zero
    '{8'hA0, 32'd1000,    32'd1001, 32'h0000FFFF, 1'b1}, // R5 16-bit wrap
    '{8'hE0, 32'd1000,    32'd1001, 32'd1000,     1'b1}, // R6 reload
    '{8'hE0, 32'd1000,    32'd2001, 32'd0,        1'b1}, // R6 second period
    '{8'hA2, 32'd5,       32'd6,    32'hFFFFFFFF, 1'b1}, // R5 32-bit wrap
    '{8'hA1, 32'd5,       32'd9,    32'd0,        1'b1}, // R7 one-shot
    '{8'hE1, 32'd5,       32'd9,    32'd0,        1'b1}, // R7 over periodic
    '{8'hA4, 32'd10,      32'd64,   32'd6,        1'b0}, // R3 div 16
    '{8'hA8, 32'd3,       32'd767,  32'd1,        1'b0}, // R3 div 256 short
    '{8'hA8, 32'd3,       32'd768,  32'd0,        1'b1}, // R3 div 256
    '{8'hAC, 32'd3,       32'd768,  32'd0,        1'b1}, // R3 select 3
    '{8'hA0, 32'h12345,   32'd5,    32'h00002340, 1'b0}, // R8 low bits
    '{8'hA2, 32'h10002,   32'd3,    32'h0000FFFF, 1'b0}, // R8 wide borrow
    '{8'hE0, 32'h12345,   32'd9030, 32'h00002345, 1'b1}  // R8 masked reload
  };

  task automatic check(input string what, input logic [31:0] got,
                       input logic [31:0] exp);
    nChecks++;
    if (got !== exp) begin
      nFail++;
      $display("FAIL %s got %h expected %h", what, got, exp);
    end
  endtask

  task automatic apbWrite(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    pSel = 1'b1; pWrite = 1'b1; pEnable = 1'b0; pAddr = a; pWdata = d;
    @(negedge clk);
    pEnable = 1'b1;
    @(negedge clk);
    pSel = 1'b0; pEnable = 1'b0; pWrite = 1'b0;
  endtask

  task automatic apbRead(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    pAddr = a; pSel = 1'b1; pWrite = 1'b0;
    #1 d = pRdata;
    pSel = 1'b0;
  endtask

  task automatic runTicks(input int n);
    @(negedge clk);
    tickEn = 1'b1;
    repeat (n) @(negedge clk);
    tickEn = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nChecks++; nFail++;
      $display("FAIL watchdog expired got 1 expected 0");
      $display("[TB] %0d tests run, %0d failed", nChecks, nFail);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd, held;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state of every register of both channels
    for (int c = 0; c < 2; c++)
      for (int r = 0; r < 7; r++) begin
        apbRead(12'(c * 32 + r * 4), rd);
        check($sformatf("R1 reset reg ch%0d off %0d", c, r * 4), rd, 32'd0);
      end
    check("R10 reset irqAny", {31'd0, irqAny}, 32'd0);

    // Table walk on channel 1: R2 R3 R4 R5 R6 R7 R8
    for (int i = 0; i < NV; i++) begin
      apbWrite(A_CTRL, 32'd0);
      apbWrite(A_CLR, 32'd0);
      apbWrite(A_LOAD, VECS[i].load);
      apbWrite(A_CTRL, {24'd0, VECS[i].ctrl});
      runTicks(int'(VECS[i].ticks));
      apbRead(A_VAL, rd);
      check($sformatf("R2 table[%0d] value", i), rd, VECS[i].expVal);
      apbRead(A_RIS, rd);
      check($sformatf("R4 table[%0d] raw status", i), rd, {31'd0, VECS[i].expRis});
    end

    // R10 masking by interrupt enable
    apbWrite(A_CTRL, 32'd0);
    apbWrite(A_CLR, 32'd0);
    apbWrite(A_LOAD, 32'd2);
    apbWrite(A_CTRL, 32'h80);
    runTicks(2);
    apbRead(A_RIS, rd);
    check("R10 raw set without enable", rd, 32'd1);
    apbRead(A_MIS, rd);
    check("R10 masked off", rd, 32'd0);
    check("R10 irqOne masked", {31'd0, irqOne}, 32'd0);
    apbWrite(A_CTRL, 32'hA0);
    apbRead(A_MIS, rd);
    check("R10 masked on", rd, 32'd1);
    check("R10 irqOne", {31'd0, irqOne}, 32'd1);
    check("R10 irqAny", {31'd0, irqAny}, 32'd1);
    check("R10 irqTwo idle", {31'd0, irqTwo}, 32'd0);

    // R9 clear with arbitrary data
    apbWrite(A_CLR, 32'hDEADBEEF);
    apbRead(A_RIS, rd);
    check("R9 clear any data", rd, 32'd0);
    check("R9 irqOne after clear", {31'd0, irqOne}, 32'd0);

    // R2 tickEn low: no counting while enabled
    apbWrite(A_LOAD, 32'd40);
    repeat (10) @(negedge clk);
    apbRead(A_VAL, rd);
    check("R2 no tick no count", rd, 32'd40);

    // R13 control 0 stops the channel
    runTicks(5);
    apbWrite(A_CTRL, 32'd0);
    apbRead(A_VAL, held);
    check("R13 value before stop", held, 32'd35);
    runTicks(20);
    apbRead(A_VAL, rd);
    check("R13 value holds", rd, held);

    // R1 channel 2 offsets, R12 background load, R11 readback
    apbWrite(CH2 + A_LOAD, 32'd10);
    apbWrite(CH2 + A_CTRL, 32'hE0);
    apbRead(CH2 + A_CTRL, rd);
    check("R1 ch2 control readback", rd, 32'hE0);
    runTicks(3);
    apbWrite(CH2 + A_BG, 32'd50);
    apbRead(CH2 + A_VAL, rd);
    check("R12 value undisturbed", rd, 32'd7);
    apbRead(CH2 + A_LOAD, rd);
    check("R11 load reads reload", rd, 32'd50);
    apbRead(CH2 + A_BG, rd);
    check("R11 bgload reads reload", rd, 32'd50);
    runTicks(7);
    check("R10 irqTwo", {31'd0, irqTwo}, 32'd1);
    check("R10 irqAny from ch2", {31'd0, irqAny}, 32'd1);
    check("R10 irqOne independent", {31'd0, irqOne}, 32'd0);
    runTicks(1);
    apbRead(CH2 + A_VAL, rd);
    check("R12 reload uses background value", rd, 32'd50);
    apbRead(A_VAL, rd);
    check("R1 ch1 untouched by ch2", rd, held);

    // R11 load write restarts the divider
    apbWrite(CH2 + A_CTRL, 32'hE4);
    apbWrite(CH2 + A_LOAD, 32'd10);
    runTicks(8);
    apbWrite(CH2 + A_LOAD, 32'd10);
    runTicks(8);
    apbRead(CH2 + A_VAL, rd);
    check("R11 divider restarted", rd, 32'd10);
    runTicks(8);
    apbRead(CH2 + A_VAL, rd);
    check("R11 first divided tick", rd, 32'd9);

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", nChecks, nFail);
    $finish;
  end
endmodule